// File: doc/BRIEF.md
# Multichannel DMA Control and Status Register Block

This block is the register file that sits beside a multichannel DMA engine. It holds a bitmap for each channel attribute: request enable, error-interrupt enable, interrupt pending, error pending and done. A 32-bit register bus reaches each 64-bit bitmap as two words. The low word covers channels 31..0 and the high word covers channels 63..32. The engine reports per-channel done and error pulses together with a vector that classifies the error. The block turns these into pending bits, a single interrupt line and a frozen error-status word.

Software seldom rewrites a whole bitmap. Instead it writes a channel number to one of a row of command registers. Each command register sets or clears the bit of that one channel, or issues a one-cycle start pulse to it. Because no read-modify-write is needed, drivers that work on different channels do not race each other. The error-status word keeps a snapshot of the first error. That snapshot stays until software has cleared every error bit.

Top module: `dmacsr_top`

## Requirements
- R1: After a synchronous reset, every bitmap, the control register and the error-status word read 0, `start_o` is 0 and `irq_o` is low.
- R2: Every bitmap is 64 bits wide. The low word (even address +1: 3, 5, 7, 9, 11) holds channels 31..0 in bits 31..0. The high word (2, 4, 6, 8, 10) holds channels 63..32 in bits 31..0. Full-word writes to the request-enable (2/3) and error-interrupt-enable (4/5) words replace the word.
- R3: Writing channel number N in `bus_wdata[7:0]` has these effects: to address 12 it sets request-enable bit N, to 13 it clears it, to 14 it sets error-interrupt-enable bit N, and to 15 it clears it. No other bit changes.
- R4: Writing N to address 16 clears interrupt-pending bit N. Writing N to 17 clears error bit N. Writing N to 18 clears done bit N.
- R5: Writing N to address 19 drives `start_o` with only bit N high, for exactly the one cycle after the write edge.
- R6: The interrupt-pending words (6/7) and the error words (8/9) are write-one-to-clear. Writing all ones to a word clears all 32 of its bits.
- R7: The error-status word is at address 1. Its layout is: bit 31 valid, bit 15 group-priority error, bit 14 channel-priority error, bits 13:8 channel number, and bits 7:0 the detail flags. These come from `err_kind[9:0]`: bit 9 maps to bit 15, bit 8 maps to bit 14, and bits 7:0 map to bits 7:0. The word is loaded when an error pulse arrives while it is not valid. If several channels err together, it records the lowest channel.
- R8: While valid and while any error bit is set, the error-status word does not change. One cycle after the error bitmap becomes empty, the word returns to 0, and a later error is recorded again.
- R9: The control register at address 0 keeps written bits 31 (dynamic clock), 3 (round-robin group) and 2 (round-robin channel), drives them on the three control outputs, and reads 0 in all other bits.
- R10: `irq_o` is high when any interrupt-pending bit is set, or when any error bit is set whose error-interrupt enable is also set.
- R11: A command write whose channel value is 64 or more changes no bitmap and produces no start pulse.
- R12: A `ch_done` pulse sets that channel's done and interrupt-pending bits, and a `ch_err` pulse sets its error bit. A hardware set takes priority over a software clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ch_done | input | 64 | Per-channel completion pulses |
| ch_err | input | 64 | Per-channel error pulses |
| err_kind | input | 10 | Error classification that accompanies `ch_err` |
| start_o | output | 64 | One-cycle start pulse per channel |
| irq_o | output | 1 | Combined interrupt |
| req_en_o | output | 64 | Request-enable bitmap |
| err_int_en_o | output | 64 | Error-interrupt-enable bitmap |
| int_pend_o | output | 64 | Interrupt-pending bitmap |
| err_pend_o | output | 64 | Error bitmap |
| done_o | output | 64 | Done bitmap |
| dyn_clk_en_o | output | 1 | Dynamic clock enable from control bit 31 |
| rr_group_o | output | 1 | Round-robin group arbitration from control bit 3 |
| rr_chan_o | output | 1 | Round-robin channel arbitration from control bit 2 |

## Verification
The bench builds the block with the default of 64 channels, so every bitmap fills both of its words. With this setting channel 63 is the last legal command value and 64 is the first rejected one, and the bench exercises both sides of that boundary. Done and error pulses are placed on channels in both halves. This covers the case where the error-status word has to stay frozen while a high-word error bit is still pending after the low word has been cleared. It also checks that the lowest erring channel wins when two channels fail together.

// File: rtl/dmacsr_pkg.sv
package dmacsr_pkg;

    localparam int DW     = 32;
    localparam int AW     = 5;
    localparam int MAP_W  = 2 * DW;
    localparam int KIND_W = 10;
    localparam int CIDX_W = $clog2(MAP_W);

    typedef enum logic [AW-1:0] {
        A_CTRL    = 5'd0,
        A_ESTAT   = 5'd1,
        A_REQEN_H = 5'd2,
        A_REQEN_L = 5'd3,
        A_EEI_H   = 5'd4,
        A_EEI_L   = 5'd5,
        A_INT_H   = 5'd6,
        A_INT_L   = 5'd7,
        A_ERR_H   = 5'd8,
        A_ERR_L   = 5'd9,
        A_DONE_H  = 5'd10,
        A_DONE_L  = 5'd11,
        A_C_SREQ  = 5'd12,
        A_C_CREQ  = 5'd13,
        A_C_SEEI  = 5'd14,
        A_C_CEEI  = 5'd15,
        A_C_CINT  = 5'd16,
        A_C_CERR  = 5'd17,
        A_C_CDONE = 5'd18,
        A_C_START = 5'd19
    } reg_addr_e;

    typedef enum logic { MAP_RW, MAP_W1C } map_mode_e;

    typedef struct packed {
        logic              valid;
        logic [14:0]       rsvd;
        logic              grp_prio;
        logic              ch_prio;
        logic [CIDX_W-1:0] chan;
        logic [7:0]        detail;
    } err_stat_t;

    typedef struct packed {
        logic [MAP_W-1:0] set_req;
        logic [MAP_W-1:0] clr_req;
        logic [MAP_W-1:0] set_eei;
        logic [MAP_W-1:0] clr_eei;
        logic [MAP_W-1:0] clr_int;
        logic [MAP_W-1:0] clr_err;
        logic [MAP_W-1:0] clr_done;
        logic [MAP_W-1:0] start;
    } cmd_masks_t;

    localparam logic [DW-1:0] CTRL_MASK = 32'h8000_000C;

    function automatic logic [MAP_W-1:0] chan_onehot(input logic [7:0] val, input int nch);
        logic [MAP_W-1:0] r;
        r = '0;
        if (int'(val) < nch) r[val[CIDX_W-1:0]] = 1'b1;
        return r;
    endfunction

    function automatic logic [MAP_W-1:0] chan_mask(input int nch);
        logic [MAP_W-1:0] r;
        r = '0;
        for (int i = 0; i < MAP_W; i++) r[i] = (i < nch);
        return r;
    endfunction

endpackage

// File: rtl/dmacsr_cmd_dec.sv
module dmacsr_cmd_dec
    import dmacsr_pkg::*;
#(
    parameter int N_CH = 64
) (
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    cmd_byte,
    output cmd_masks_t    masks
);
    reg_addr_e        a;
    logic [MAP_W-1:0] oh;

    assign a  = reg_addr_e'(addr);
    assign oh = chan_onehot(cmd_byte, N_CH);

    always_comb begin
        masks = '0;
        if (we) begin
            case (a)
                A_C_SREQ:  masks.set_req  = oh;
                A_C_CREQ:  masks.clr_req  = oh;
                A_C_SEEI:  masks.set_eei  = oh;
                A_C_CEEI:  masks.clr_eei  = oh;
                A_C_CINT:  masks.clr_int  = oh;
                A_C_CERR:  masks.clr_err  = oh;
                A_C_CDONE: masks.clr_done = oh;
                A_C_START: masks.start    = oh;
                default:   masks          = '0;
            endcase
        end
    end
endmodule

// File: rtl/dmacsr_bitmap.sv
module dmacsr_bitmap
    import dmacsr_pkg::*;
#(
    parameter int        N_CH = 64,
    parameter map_mode_e MODE = MAP_RW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [MAP_W-1:0] hw_set,
    input  logic [MAP_W-1:0] sw_set,
    input  logic [MAP_W-1:0] sw_clr,
    input  logic             wr_hi,
    input  logic             wr_lo,
    input  logic [DW-1:0]    wdata,
    output logic [MAP_W-1:0] map_q
);
    localparam logic [MAP_W-1:0] CH_MASK = chan_mask(N_CH);

    logic [MAP_W-1:0] after_cmd;
    logic [MAP_W-1:0] after_word;
    logic [MAP_W-1:0] map_d;

    assign after_cmd = (map_q & ~sw_clr) | sw_set;

    generate
        if (MODE == MAP_RW) begin : g_rw
            always_comb begin
                after_word = after_cmd;
                if (wr_hi) after_word[MAP_W-1:DW] = wdata;
                if (wr_lo) after_word[DW-1:0]     = wdata;
            end
        end else begin : g_w1c
            always_comb begin
                after_word = after_cmd;
                if (wr_hi) after_word[MAP_W-1:DW] = after_cmd[MAP_W-1:DW] & ~wdata;
                if (wr_lo) after_word[DW-1:0]     = after_cmd[DW-1:0] & ~wdata;
            end

            assert_w1c_lo_R6: assert property (@(posedge clk) disable iff (rst)
                (wr_lo && !(|hw_set[DW-1:0]) && !(|sw_set[DW-1:0]))
                |=> ((map_q[DW-1:0] & $past(wdata)) == '0));
        end
    endgenerate

    assign map_d = (after_word | hw_set) & CH_MASK;

    always_ff @(posedge clk) begin
        if (rst) map_q <= '0;
        else     map_q <= map_d;
    end

    assert_hwset_wins_R12: assert property (@(posedge clk) disable iff (rst)
        (|hw_set) |=> ((map_q & $past(hw_set & CH_MASK)) == $past(hw_set & CH_MASK)));
endmodule

// File: rtl/dmacsr_errcap.sv
module dmacsr_errcap
    import dmacsr_pkg::*;
#(
    parameter int N_CH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MAP_W-1:0]  ch_err,
    input  logic [KIND_W-1:0] err_kind,
    input  logic [MAP_W-1:0]  err_map,
    output err_stat_t         stat_q
);
    logic [CIDX_W-1:0] low_idx;
    logic              any_err;
    logic              map_empty;
    err_stat_t         stat_d;

    assign any_err   = |ch_err;
    assign map_empty = (err_map == '0);

    always_comb begin
        low_idx = '0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (ch_err[i]) low_idx = CIDX_W'(i);
        end
    end

    always_comb begin
        stat_d = stat_q;
        if (any_err && (!stat_q.valid || map_empty)) begin
            stat_d          = '0;
            stat_d.valid    = 1'b1;
            stat_d.grp_prio = err_kind[9];
            stat_d.ch_prio  = err_kind[8];
            stat_d.chan     = low_idx;
            stat_d.detail   = err_kind[7:0];
        end else if (map_empty) begin
            stat_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_d;
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (stat_q.valid && !map_empty) |=> $stable(stat_q));

    assert_release_R8: assert property (@(posedge clk) disable iff (rst)
        (stat_q.valid && map_empty && !any_err) |=> !stat_q.valid);

    assert_capture_R7: assert property (@(posedge clk) disable iff (rst)
        (!stat_q.valid && any_err) |=> stat_q.valid);
endmodule

// File: rtl/dmacsr_top.sv
module dmacsr_top
    import dmacsr_pkg::*;
#(
    parameter int N_CH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [MAP_W-1:0]  ch_done,
    input  logic [MAP_W-1:0]  ch_err,
    input  logic [KIND_W-1:0] err_kind,
    output logic [MAP_W-1:0]  start_o,
    output logic              irq_o,
    output logic [MAP_W-1:0]  req_en_o,
    output logic [MAP_W-1:0]  err_int_en_o,
    output logic [MAP_W-1:0]  int_pend_o,
    output logic [MAP_W-1:0]  err_pend_o,
    output logic [MAP_W-1:0]  done_o,
    output logic              dyn_clk_en_o,
    output logic              rr_group_o,
    output logic              rr_chan_o
);
    localparam logic [MAP_W-1:0] CH_MASK = chan_mask(N_CH);

    reg_addr_e        a;
    cmd_masks_t       cmd;
    logic [DW-1:0]    ctrl_q;
    logic [MAP_W-1:0] start_q;
    logic [MAP_W-1:0] done_in;
    logic [MAP_W-1:0] err_in;
    err_stat_t        estat;
    logic             is_cmd;

    assign a       = reg_addr_e'(bus_addr);
    assign done_in = ch_done & CH_MASK;
    assign err_in  = ch_err & CH_MASK;
    assign is_cmd  = (bus_addr >= A_C_SREQ) && (bus_addr <= A_C_START);

    dmacsr_cmd_dec #(.N_CH(N_CH)) u_dec (
        .we       (bus_we),
        .addr     (bus_addr),
        .cmd_byte (bus_wdata[7:0]),
        .masks    (cmd)
    );

    dmacsr_bitmap #(.N_CH(N_CH), .MODE(MAP_RW)) u_reqen (
        .clk (clk), .rst (rst),
        .hw_set ('0), .sw_set (cmd.set_req), .sw_clr (cmd.clr_req),
        .wr_hi (bus_we && a == A_REQEN_H), .wr_lo (bus_we && a == A_REQEN_L),
        .wdata (bus_wdata), .map_q (req_en_o)
    );

    dmacsr_bitmap #(.N_CH(N_CH), .MODE(MAP_RW)) u_eei (
        .clk (clk), .rst (rst),
        .hw_set ('0), .sw_set (cmd.set_eei), .sw_clr (cmd.clr_eei),
        .wr_hi (bus_we && a == A_EEI_H), .wr_lo (bus_we && a == A_EEI_L),
        .wdata (bus_wdata), .map_q (err_int_en_o)
    );

    dmacsr_bitmap #(.N_CH(N_CH), .MODE(MAP_W1C)) u_int (
        .clk (clk), .rst (rst),
        .hw_set (done_in), .sw_set ('0), .sw_clr (cmd.clr_int),
        .wr_hi (bus_we && a == A_INT_H), .wr_lo (bus_we && a == A_INT_L),
        .wdata (bus_wdata), .map_q (int_pend_o)
    );

    dmacsr_bitmap #(.N_CH(N_CH), .MODE(MAP_W1C)) u_err (
        .clk (clk), .rst (rst),
        .hw_set (err_in), .sw_set ('0), .sw_clr (cmd.clr_err),
        .wr_hi (bus_we && a == A_ERR_H), .wr_lo (bus_we && a == A_ERR_L),
        .wdata (bus_wdata), .map_q (err_pend_o)
    );

    dmacsr_bitmap #(.N_CH(N_CH), .MODE(MAP_RW)) u_done (
        .clk (clk), .rst (rst),
        .hw_set (done_in), .sw_set ('0), .sw_clr (cmd.clr_done),
        .wr_hi (1'b0), .wr_lo (1'b0),
        .wdata (bus_wdata), .map_q (done_o)
    );

    dmacsr_errcap #(.N_CH(N_CH)) u_ecap (
        .clk (clk), .rst (rst),
        .ch_err (err_in), .err_kind (err_kind),
        .err_map (err_pend_o), .stat_q (estat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            start_q <= '0;
        end else begin
            start_q <= cmd.start;
            if (bus_we && a == A_CTRL) ctrl_q <= bus_wdata & CTRL_MASK;
        end
    end

    assign start_o      = start_q;
    assign dyn_clk_en_o = ctrl_q[31];
    assign rr_group_o   = ctrl_q[3];
    assign rr_chan_o    = ctrl_q[2];
    assign irq_o        = (|int_pend_o) || (|(err_pend_o & err_int_en_o));

    always_comb begin
        case (a)
            A_CTRL:    bus_rdata = ctrl_q;
            A_ESTAT:   bus_rdata = estat;
            A_REQEN_H: bus_rdata = req_en_o[MAP_W-1:DW];
            A_REQEN_L: bus_rdata = req_en_o[DW-1:0];
            A_EEI_H:   bus_rdata = err_int_en_o[MAP_W-1:DW];
            A_EEI_L:   bus_rdata = err_int_en_o[DW-1:0];
            A_INT_H:   bus_rdata = int_pend_o[MAP_W-1:DW];
            A_INT_L:   bus_rdata = int_pend_o[DW-1:0];
            A_ERR_H:   bus_rdata = err_pend_o[MAP_W-1:DW];
            A_ERR_L:   bus_rdata = err_pend_o[DW-1:0];
            A_DONE_H:  bus_rdata = done_o[MAP_W-1:DW];
            A_DONE_L:  bus_rdata = done_o[DW-1:0];
            default:   bus_rdata = '0;
        endcase
    end

    assert_start_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(start_o));

    assert_badch_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_we && is_cmd && (int'(bus_wdata[7:0]) >= N_CH))
        |=> ($stable(req_en_o) && $stable(err_int_en_o) && (start_o == '0)));

    assert_ctrl_reserved_R9: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q & ~CTRL_MASK) == '0);
endmodule

// File: tb/tb_dmacsr_top.sv
module tb_dmacsr_top;
    import dmacsr_pkg::*;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_we = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [DW-1:0]     bus_wdata = '0;
    logic [DW-1:0]     bus_rdata;
    logic [MAP_W-1:0]  ch_done = '0;
    logic [MAP_W-1:0]  ch_err = '0;
    logic [KIND_W-1:0] err_kind = '0;
    logic [MAP_W-1:0]  start_o, req_en_o, err_int_en_o, int_pend_o, err_pend_o, done_o;
    logic              irq_o, dyn_clk_en_o, rr_group_o, rr_chan_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    sb_item_t sb_q[$];

    always #2.5 clk = ~clk;

    dmacsr_top #(.N_CH(64)) dut (
        .clk (clk), .rst (rst), .bus_we (bus_we), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .ch_done (ch_done),
        .ch_err (ch_err), .err_kind (err_kind), .start_o (start_o), .irq_o (irq_o),
        .req_en_o (req_en_o), .err_int_en_o (err_int_en_o), .int_pend_o (int_pend_o),
        .err_pend_o (err_pend_o), .done_o (done_o), .dyn_clk_en_o (dyn_clk_en_o),
        .rr_group_o (rr_group_o), .rr_chan_o (rr_chan_o)
    );

    // Monitor: compares read data with the scoreboard at the falling edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (bus_rdata !== it.exp) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic wr(input logic [AW-1:0] ad, input logic [31:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = ad; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] ad, input logic [31:0] e, input string tag);
        sb_item_t it;
        @(posedge clk); #1;
        bus_addr = ad;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic chk(input logic [63:0] got, input logic [63:0] e, input string tag);
        n_checks++;
        if (got !== e) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, e);
        end
    endtask

    task automatic done_pulse(input logic [63:0] m);
        @(posedge clk); #1; ch_done = m;
        @(posedge clk); #1; ch_done = '0;
    endtask

    task automatic err_pulse(input logic [63:0] m, input logic [9:0] k);
        @(posedge clk); #1; ch_err = m; err_kind = k;
        @(posedge clk); #1; ch_err = '0; err_kind = '0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(A_CTRL, 32'h0, "R1 ctrl");
        rd(A_ESTAT, 32'h0, "R1 estat");
        rd(A_REQEN_L, 32'h0, "R1 reqen lo");
        chk(irq_o, 0, "R1 irq");
        chk(start_o, 0, "R1 start");

        // R3 / R2 set and clear request enables in both halves
        wr(A_C_SREQ, 5); wr(A_C_SREQ, 40); wr(A_C_SREQ, 63);
        rd(A_REQEN_L, 32'h0000_0020, "R3 reqen lo");
        rd(A_REQEN_H, 32'h8000_0100, "R2 reqen hi");
        wr(A_C_CREQ, 40);
        rd(A_REQEN_H, 32'h8000_0000, "R3 clr reqen hi");

        // R11 out-of-range channel numbers
        wr(A_C_SREQ, 64); wr(A_C_SREQ, 127); wr(A_C_CREQ, 69);
        rd(A_REQEN_H, 32'h8000_0000, "R11 reqen hi");
        rd(A_REQEN_L, 32'h0000_0020, "R11 reqen lo");

        // R2 full-word replace
        wr(A_REQEN_L, 32'hA5A5_0000);
        rd(A_REQEN_L, 32'hA5A5_0000, "R2 word write");
        chk(req_en_o, 64'h8000_0000_A5A5_0000, "R2 req_en_o");

        // R9 control
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, 32'h8000_000C, "R9 ctrl");
        chk({dyn_clk_en_o, rr_group_o, rr_chan_o}, 3'b111, "R9 outputs");

        // R12 / R10 / R4 / R6 done and interrupt pending
        done_pulse((64'd1 << 3) | (64'd1 << 35));
        chk(irq_o, 1, "R10 irq on pending");
        rd(A_DONE_L, 32'h8, "R12 done lo");
        rd(A_INT_H, 32'h8, "R12 int hi");
        wr(A_C_CDONE, 3);
        rd(A_DONE_L, 32'h0, "R4 clr done");
        wr(A_C_CINT, 3);
        rd(A_INT_L, 32'h0, "R4 clr int");
        chk(irq_o, 1, "R10 irq still pending hi");
        wr(A_INT_H, 32'hFFFF_FFFF);
        rd(A_INT_H, 32'h0, "R6 w1c int hi");
        chk(irq_o, 0, "R10 irq cleared");

        // R5 start pulse
        wr(A_C_START, 33);
        chk(start_o, 64'd1 << 33, "R5 start pulse");
        @(posedge clk); #1;
        chk(start_o, 0, "R5 start one cycle");
        wr(A_C_START, 70);
        chk(start_o, 0, "R11 start ignored");

        // R7 / R8 error capture
        err_pulse((64'd1 << 12) | (64'd1 << 50), 10'b10_1000_0001);
        rd(A_ESTAT, 32'h8000_8C81, "R7 first error");
        chk(irq_o, 0, "R10 error without enable");
        wr(A_C_SEEI, 50);
        chk(irq_o, 1, "R10 error with enable");
        err_pulse(64'd1 << 7, 10'h002);
        rd(A_ESTAT, 32'h8000_8C81, "R8 held on second error");
        rd(A_ERR_L, 32'h0000_1080, "R12 err lo");
        wr(A_C_CERR, 12);
        rd(A_ERR_L, 32'h0000_0080, "R4 clr err");
        wr(A_ERR_L, 32'hFFFF_FFFF);
        rd(A_ERR_L, 32'h0, "R6 w1c err lo");
        rd(A_ESTAT, 32'h8000_8C81, "R8 held with hi pending");
        wr(A_C_CERR, 50);
        rd(A_ESTAT, 32'h0, "R8 released");
        chk(irq_o, 0, "R10 irq after err clear");
        err_pulse(64'd1 << 20, 10'h108);
        rd(A_ESTAT, 32'h8000_5408, "R7 recapture");

        // R12 hardware set beats software clear in the same cycle
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = A_C_CDONE; bus_wdata = 9; ch_done = 64'd1 << 9;
        @(posedge clk); #1;
        bus_we = 1'b0; ch_done = '0;
        rd(A_DONE_L, 32'h0000_0200, "R12 set wins");

        @(posedge clk); #1;
        finished = 1;
        finish_run();
    end
endmodule